// File: doc/BRIEF.md
# PCI Bridge Interrupt and Status Register Block

This block is the register-mapped interrupt front end of a PCI host bridge. Software reaches it over an APB slave port at two word offsets: a control register and a status register. The control register holds one enable per PCI interrupt line, an error-interrupt enable, a system-error reporting enable, an error-response enable and the drive for the PCI bus reset. The status register reports the hardware straps, the live level of the four active-low INTx# pins, and six sticky event flags that are cleared by writing one.

Bus error events (system error, master abort, target abort, parity error) and DMA events (done, error) arrive from neighbouring logic as single-cycle pulses. A 2-bit strapped interrupt mode decides how the pending sources reach the system. In the merged modes (0 and 1) all enabled sources drive one shared level-sensitive interrupt. In the split modes (2 and 3) each INTx line gets its own output, and the error interrupt rides on the first line. Mode bit 0 steers DMA events onto a dedicated DMA interrupt output. Otherwise they join the shared output in mode 0, or the first line output in mode 2.

Top module: `pci_irq_csr`

## Requirements
- R1: After reset the control register reads 0, all six sticky flags are 0, and every interrupt output, `pciRstOut` and `errRespEn` are 0.
- R2: The control register is at offset 0x0. Its writable bits are 31 (bus reset, drives `pciRstOut`), 27 (system-error reporting enable), 25 (error interrupt enable), 24 (error response enable, drives `errRespEn`) and 3:0 (enables for lines A..D). All other bits read 0.
- R3: The status register is at offset 0x4. Bit 31 shows `notHostSlot`, bit 30 shows `masterCap` and bits 25:24 show `irqMode`. Bits 11:8 show the INTx# pin levels (bit 8+i is line i, 0 means asserting) after `SYNC_STAGES` clock edges. All bits not named in R3, R4 or R5 read 0.
- R4: Error pulses set sticky status bits: 17 system error, 14 master abort, 13 target abort, 12 parity error. Writing 1 to a bit at offset 0x4 clears it, and writing 0 leaves it unchanged.
- R5: DMA pulses set sticky status bits 16 (done) and 15 (error). They clear the same way as in R4.
- R6: When a pulse sets a sticky bit in the same cycle that a write tries to clear it, the bit ends up set.
- R7: In modes 0 and 1, `sysIrq` is high while any line i has its enable set and its pin low, or while the error source of R8 is active. `lineIrq` stays 0 in these modes.
- R8: The error source is active when control bit 25 is set and at least one of these holds: parity, target-abort or master-abort is pending, or system error is pending with control bit 27 set.
- R9: DMA pending means bit 16 or bit 15 is set. In mode 0 it drives `sysIrq`, in modes 1 and 3 it drives `dmaIrq`, and in mode 2 it drives `lineIrq[0]`. `dmaIrq` is 0 in modes 0 and 2.
- R10: In modes 2 and 3, `lineIrq[i]` is high while line i is enabled and its pin is low. The error source is ORed onto `lineIrq[0]`, and `sysIrq` is 0.
- R11: Interrupt outputs are levels. They stay high for as long as a source is pending and drop once it is cleared or released.
- R12: Writes to an unmapped offset change nothing. Writes to read-only status bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| intxN | input | 4 | PCI INTA#..INTD# pins, active low |
| irqMode | input | 2 | Strapped interrupt mode |
| notHostSlot | input | 1 | Strap: core is not in the host slot |
| masterCap | input | 1 | Strap: master capability |
| errSysPulse | input | 1 | System error event pulse |
| errMabortPulse | input | 1 | Master abort event pulse |
| errTabortPulse | input | 1 | Target abort event pulse |
| errParityPulse | input | 1 | Parity error event pulse |
| dmaDonePulse | input | 1 | DMA done event pulse |
| dmaErrPulse | input | 1 | DMA error event pulse |
| sysIrq | output | 1 | Shared system interrupt (modes 0 and 1) |
| dmaIrq | output | 1 | Dedicated DMA interrupt (modes 1 and 3) |
| lineIrq | output | 4 | Per-line interrupts (modes 2 and 3) |
| pciRstOut | output | 1 | PCI bus reset drive |
| errRespEn | output | 1 | Error response enable for illegal accesses |

## Verification
A sticky flag that is lost or stuck shows up on the interrupt outputs in the cycle after the event pulse or the clearing write. The next status read shows the wrong bit pattern. A wrong line enable or a wrong mode decode routes a source to the wrong output, and this appears in the first checked cycle after the change. Pin levels can only be compared once `SYNC_STAGES` edges have passed. A synchronizer with the wrong depth therefore shows as a status or interrupt mismatch at exactly that delay.

// File: rtl/pci_irq_pkg.sv
`timescale 1ns/1ps
package pci_irq_pkg;
  localparam int LINES  = 4;
  localparam int DATA_W = 32;
  localparam int EVT_W  = 6;

  // register offsets (byte addresses)
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 4;

  // control bit positions
  localparam int CB_BUSRST  = 31;
  localparam int CB_SERREN  = 27;
  localparam int CB_ERRIRQ  = 25;
  localparam int CB_ERRRESP = 24;

  // status bit positions
  localparam int SB_NOHOST = 31;
  localparam int SB_MASTER = 30;
  localparam int SB_MODE   = 24;
  localparam int SB_EVT    = 12;
  localparam int SB_PIN    = 8;

  // sticky event index, offset from SB_EVT
  localparam int EV_PARITY  = 0;
  localparam int EV_TABORT  = 1;
  localparam int EV_MABORT  = 2;
  localparam int EV_DMAERR  = 3;
  localparam int EV_DMADONE = 4;
  localparam int EV_SYSERR  = 5;

  localparam logic [DATA_W-1:0] CTRL_WMASK =
    (DATA_W'(1) << CB_BUSRST) | (DATA_W'(1) << CB_SERREN) |
    (DATA_W'(1) << CB_ERRIRQ) | (DATA_W'(1) << CB_ERRRESP) |
    DATA_W'((1 << LINES) - 1);

  typedef struct packed {
    logic wrCtrl;
    logic wrStat;
    logic rdCtrl;
    logic rdStat;
  } regStrobes_t;
endpackage

// File: rtl/pci_irq_ctrl.sv
`timescale 1ns/1ps
module pci_irq_ctrl
  import pci_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output regStrobes_t       strb
);
  logic wrAccess;
  logic rdAccess;
  logic hitCtrl;
  logic hitStat;

  assign wrAccess = psel & penable & pwrite;
  assign rdAccess = psel & ~pwrite;
  assign hitCtrl  = (paddr == ADDR_W'(OFS_CTRL));
  assign hitStat  = (paddr == ADDR_W'(OFS_STAT));

  always_comb begin
    strb.wrCtrl = wrAccess & hitCtrl;
    strb.wrStat = wrAccess & hitStat;
    strb.rdCtrl = rdAccess & hitCtrl;
    strb.rdStat = rdAccess & hitStat;
  end
endmodule

// File: rtl/pci_irq_dp.sv
`timescale 1ns/1ps
module pci_irq_dp
  import pci_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strb,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [LINES-1:0]  intxN,
  input  logic [1:0]        irqMode,
  input  logic              notHostSlot,
  input  logic              masterCap,
  input  logic [EVT_W-1:0]  evPulse,
  output logic [DATA_W-1:0] prdata,
  output logic [DATA_W-1:0] ctrlQ,
  output logic [EVT_W-1:0]  stickyQ,
  output logic [LINES-1:0]  pinSync
);
  logic [LINES-1:0]  syncQ [SYNC_STAGES];
  logic [EVT_W-1:0]  clrVec;
  logic [DATA_W-1:0] statusWord;

  // pin synchronizer, idle level is high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '1;
    end else begin
      syncQ[0] <= intxN;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign pinSync = syncQ[SYNC_STAGES-1];

  // control register
  always_ff @(posedge clk) begin
    if (!rstN)            ctrlQ <= '0;
    else if (strb.wrCtrl) ctrlQ <= pwdata & CTRL_WMASK;
  end

  // sticky events: a new event outranks a clear in the same cycle
  assign clrVec = strb.wrStat ? pwdata[SB_EVT +: EVT_W] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) stickyQ <= '0;
    else       stickyQ <= (stickyQ & ~clrVec) | evPulse;
  end

  always_comb begin
    statusWord = '0;
    statusWord[SB_NOHOST]          = notHostSlot;
    statusWord[SB_MASTER]          = masterCap;
    statusWord[SB_MODE +: 2]       = irqMode;
    statusWord[SB_EVT +: EVT_W]    = stickyQ;
    statusWord[SB_PIN +: LINES]    = pinSync;
  end

  always_comb begin
    if (strb.rdCtrl)      prdata = ctrlQ;
    else if (strb.rdStat) prdata = statusWord;
    else                  prdata = '0;
  end
endmodule

// File: rtl/pci_irq_route.sv
`timescale 1ns/1ps
module pci_irq_route
  import pci_irq_pkg::*;
(
  input  logic [1:0]       irqMode,
  input  logic [LINES-1:0] lineEn,
  input  logic [LINES-1:0] pinSync,
  input  logic [EVT_W-1:0] stickyQ,
  input  logic             errIrqEn,
  input  logic             sysErrRptEn,
  output logic             sysIrq,
  output logic             dmaIrq,
  output logic [LINES-1:0] lineIrq
);
  logic [LINES-1:0] lineAct;
  logic errSrc;
  logic dmaSrc;
  logic splitLines;
  logic dmaOwn;
  logic dmaShared;

  assign splitLines = irqMode[1];
  assign dmaOwn     = irqMode[0];

  assign errSrc = errIrqEn & (stickyQ[EV_PARITY] | stickyQ[EV_TABORT] |
                              stickyQ[EV_MABORT] |
                              (stickyQ[EV_SYSERR] & sysErrRptEn));
  assign dmaSrc    = stickyQ[EV_DMADONE] | stickyQ[EV_DMAERR];
  assign dmaShared = dmaSrc & ~dmaOwn;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      assign lineAct[i] = lineEn[i] & ~pinSync[i];
      if (i == 0) begin : g_first
        assign lineIrq[i] = splitLines & (lineAct[i] | errSrc | dmaShared);
      end else begin : g_rest
        assign lineIrq[i] = splitLines & lineAct[i];
      end
    end
  endgenerate

  assign sysIrq = ~splitLines & ((|lineAct) | errSrc | dmaShared);
  assign dmaIrq = dmaOwn & dmaSrc;
endmodule

// File: rtl/pci_irq_csr.sv
`timescale 1ns/1ps
module pci_irq_csr
  import pci_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [3:0]        intxN,
  input  logic [1:0]        irqMode,
  input  logic              notHostSlot,
  input  logic              masterCap,
  input  logic              errSysPulse,
  input  logic              errMabortPulse,
  input  logic              errTabortPulse,
  input  logic              errParityPulse,
  input  logic              dmaDonePulse,
  input  logic              dmaErrPulse,
  output logic              sysIrq,
  output logic              dmaIrq,
  output logic [3:0]        lineIrq,
  output logic              pciRstOut,
  output logic              errRespEn
);
  regStrobes_t       strb;
  logic [DATA_W-1:0] ctrlQ;
  logic [EVT_W-1:0]  stickyQ;
  logic [EVT_W-1:0]  evPulse;
  logic [LINES-1:0]  pinSync;

  assign evPulse = {errSysPulse, dmaDonePulse, dmaErrPulse,
                    errMabortPulse, errTabortPulse, errParityPulse};

  pci_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .strb    (strb)
  );

  pci_irq_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .pwdata      (pwdata),
    .intxN       (intxN),
    .irqMode     (irqMode),
    .notHostSlot (notHostSlot),
    .masterCap   (masterCap),
    .evPulse     (evPulse),
    .prdata      (prdata),
    .ctrlQ       (ctrlQ),
    .stickyQ     (stickyQ),
    .pinSync     (pinSync)
  );

  pci_irq_route u_route (
    .irqMode     (irqMode),
    .lineEn      (ctrlQ[LINES-1:0]),
    .pinSync     (pinSync),
    .stickyQ     (stickyQ),
    .errIrqEn    (ctrlQ[CB_ERRIRQ]),
    .sysErrRptEn (ctrlQ[CB_SERREN]),
    .sysIrq      (sysIrq),
    .dmaIrq      (dmaIrq),
    .lineIrq     (lineIrq)
  );

  assign pciRstOut = ctrlQ[CB_BUSRST];
  assign errRespEn = ctrlQ[CB_ERRRESP];
endmodule

// File: rtl/pci_irq_csr_chk.sv
`timescale 1ns/1ps
module pci_irq_csr_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [1:0]        irqMode,
  input logic              errParityPulse,
  input logic [5:0]        stickyQ,
  input logic              sysIrq,
  input logic              dmaIrq,
  input logic [3:0]        lineIrq,
  input logic              pciRstOut
);
  logic ctrlWr;
  logic statWr;
  assign ctrlWr = psel && penable && pwrite && (paddr == ADDR_W'(0));
  assign statWr = psel && penable && pwrite && (paddr == ADDR_W'(4));

  AST_SPLIT_NO_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    irqMode[1] |-> !sysIrq); // R10

  AST_MERGED_NO_LINES: assert property (@(posedge clk) disable iff (!rstN)
    !irqMode[1] |-> (lineIrq == 4'b0)); // R7

  AST_MODE0_NO_DMA: assert property (@(posedge clk) disable iff (!rstN)
    (irqMode == 2'b00) |-> !dmaIrq); // R9

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    errParityPulse |=> stickyQ[0]); // R6

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stickyQ[0] && !statWr) |=> stickyQ[0]); // R4

  AST_BUSRST_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (pciRstOut == $past(pwdata[31]))); // R2
endmodule

bind pci_irq_csr pci_irq_csr_chk #(.ADDR_W(ADDR_W)) chk (
  .clk            (clk),
  .rstN           (rstN),
  .psel           (psel),
  .penable        (penable),
  .pwrite         (pwrite),
  .paddr          (paddr),
  .pwdata         (pwdata),
  .irqMode        (irqMode),
  .errParityPulse (errParityPulse),
  .stickyQ        (stickyQ),
  .sysIrq         (sysIrq),
  .dmaIrq         (dmaIrq),
  .lineIrq        (lineIrq),
  .pciRstOut      (pciRstOut)
);

// File: tb/pci_irq_csr_test.sv
`timescale 1ns/1ps
module pci_irq_csr_test;
  localparam int ADDR_W = 4;
  localparam int SYNC   = 2;
  localparam logic [31:0] WMASK = 32'h8B00_000F;

  logic clk = 0;
  logic rstN = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [3:0] intxN = 4'hF;
  logic [1:0] irqMode = 2'b00;
  logic notHostSlot = 0, masterCap = 1;
  logic [5:0] ev = '0;  // [5]sys [4]dmaDone [3]dmaErr [2]mabort [1]tabort [0]parity
  logic sysIrq, dmaIrq, pciRstOut, errRespEn;
  logic [3:0] lineIrq;

  int total = 0;
  int bad = 0;
  logic finished = 0;
  logic [31:0] mCtrl = '0;
  logic [5:0] mSticky = '0;

  always #2 clk = ~clk;

  pci_irq_csr #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .intxN(intxN),
    .irqMode(irqMode), .notHostSlot(notHostSlot), .masterCap(masterCap),
    .errSysPulse(ev[5]), .errMabortPulse(ev[2]), .errTabortPulse(ev[1]),
    .errParityPulse(ev[0]), .dmaDonePulse(ev[4]), .dmaErrPulse(ev[3]),
    .sysIrq(sysIrq), .dmaIrq(dmaIrq), .lineIrq(lineIrq),
    .pciRstOut(pciRstOut), .errRespEn(errRespEn)
  );

  function automatic logic [5:0] expIrq(logic [1:0] m, logic [31:0] c,
                                        logic [3:0] pn, logic [5:0] st);
    logic [3:0] act;
    logic err, dma, sys, dm;
    logic [3:0] ln;
    act = c[3:0] & ~pn;
    err = c[25] & (st[0] | st[1] | st[2] | (st[5] & c[27]));
    dma = st[3] | st[4];
    sys = 1'b0; dm = 1'b0; ln = 4'b0;
    if (m[0]) dm = dma;
    if (!m[1]) sys = (|act) | err | (dma & ~m[0]);
    else begin
      ln = act;
      ln[0] = ln[0] | err | (dma & ~m[0]);
    end
    return {sys, dm, ln};
  endfunction

  function automatic logic [31:0] expStatus();
    return {notHostSlot, masterCap, 4'b0, irqMode, 6'b0, mSticky, intxN, 8'b0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apbWrite(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic pulse(logic [5:0] v);
    @(negedge clk);
    ev = v;
    @(negedge clk);
    ev = '0;
    mSticky = mSticky | v;
  endtask

  task automatic setCtrl(logic [31:0] d);
    apbWrite(4'h0, d);
    mCtrl = d & WMASK;
  endtask

  task automatic clearSticky(logic [5:0] v);
    apbWrite(4'h4, 32'(v) << 12);
    mSticky = mSticky & ~v;
  endtask

  task automatic settle();
    repeat (SYNC + 1) @(negedge clk);
  endtask

  task automatic checkIrq(string req);
    check(req, {26'b0, sysIrq, dmaIrq, lineIrq},
          {26'b0, expIrq(irqMode, mCtrl, intxN, mSticky)}, "irq outputs");
  endtask

  task automatic checkStatus(string req);
    logic [31:0] d;
    apbRead(4'h4, d);
    check(req, d, expStatus(), "status word");
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check("R1", {28'b0, sysIrq, dmaIrq, pciRstOut, errRespEn}, 32'b0, "scalar outputs");
    check("R1", {28'b0, lineIrq}, 32'b0, "lineIrq");
    apbRead(4'h0, d);
    check("R1", d, 32'b0, "control after reset");
    checkStatus("R1");

    // R2 control write mask and drives
    setCtrl(32'hFFFF_FFFF);
    apbRead(4'h0, d);
    check("R2", d, 32'h8B00_000F, "control readback");
    check("R2", {30'b0, pciRstOut, errRespEn}, 32'h3, "reset/errresp drives");
    setCtrl(32'h0);
    check("R2", {30'b0, pciRstOut, errRespEn}, 32'h0, "drives cleared");

    // R3 straps and pins
    notHostSlot = 1; masterCap = 0; irqMode = 2'b10; intxN = 4'b1010;
    settle();
    checkStatus("R3");
    notHostSlot = 0; masterCap = 1; irqMode = 2'b00; intxN = 4'hF;
    settle();

    // R4 and R8 error sticky and interrupt
    setCtrl(32'h0200_0000);
    pulse(6'b000001);
    checkIrq("R8");
    checkStatus("R4");
    clearSticky(6'b000001);
    checkIrq("R4");
    check("R4", {31'b0, sysIrq}, 32'b0, "sysIrq after clear");
    pulse(6'b100000);
    check("R8", {31'b0, sysIrq}, 32'b0, "sys error gated by bit27");
    setCtrl(32'h0A00_0000);
    check("R8", {31'b0, sysIrq}, 32'b1, "sys error with bit27");
    pulse(6'b000110);
    clearSticky(6'b100010);
    checkStatus("R4");
    clearSticky(6'b000100);
    checkIrq("R4");

    // R5 and R9 DMA
    setCtrl(32'h0);
    pulse(6'b010000);
    check("R9", {31'b0, sysIrq}, 32'b1, "mode0 dma on shared");
    irqMode = 2'b01;
    #1 check("R9", {30'b0, sysIrq, dmaIrq}, 32'b01, "mode1 dma separate");
    irqMode = 2'b10;
    #1 check("R9", {28'b0, lineIrq}, 32'b0001, "mode2 dma on line0");
    irqMode = 2'b11;
    #1 checkIrq("R9");
    pulse(6'b001000);
    checkStatus("R5");
    clearSticky(6'b011000);
    checkStatus("R5");
    check("R5", {31'b0, dmaIrq}, 32'b0, "dmaIrq after clear");

    // R6 event beats clear in same cycle
    irqMode = 2'b00;
    pulse(6'b000010);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = 4'h4; pwdata = 32'h0000_3000; penable = 0;
    @(negedge clk);
    penable = 1; ev = 6'b000001;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; ev = '0;
    mSticky = 6'b000001;
    checkStatus("R6");
    clearSticky(6'b000001);

    // R11 level-sensitive line interrupt
    setCtrl(32'h0000_0001);
    intxN = 4'b1110;
    settle();
    repeat (10) @(negedge clk);
    check("R11", {31'b0, sysIrq}, 32'b1, "held while pin low");
    intxN = 4'hF;
    settle();
    check("R11", {31'b0, sysIrq}, 32'b0, "drops after release");

    // R7 masked line ignored
    setCtrl(32'h0000_000D);
    intxN = 4'b1101;
    settle();
    checkIrq("R7");

    // R10 split modes
    irqMode = 2'b10;
    setCtrl(32'h0200_000F);
    intxN = 4'b0110;
    settle();
    checkIrq("R10");
    pulse(6'b000100);
    intxN = 4'b1111;
    settle();
    check("R10", {28'b0, lineIrq}, 32'b0001, "error on line0");
    clearSticky(6'b000100);
    irqMode = 2'b11;
    intxN = 4'b0101;
    settle();
    checkIrq("R10");
    intxN = 4'hF;

    // R12 unmapped write and read-only bits
    irqMode = 2'b00;
    pulse(6'b000001);
    apbWrite(4'h8, 32'hFFFF_FFFF);
    apbRead(4'h0, d);
    check("R12", d, mCtrl, "control after unmapped write");
    checkStatus("R12");
    apbWrite(4'h4, 32'hFFFC_0FFF);
    settle();
    checkStatus("R12");
    clearSticky(6'h3F);

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [5:0] evr;
      irqMode = 2'($urandom);
      intxN = 4'($urandom);
      setCtrl($urandom);
      evr = ($urandom % 3 == 0) ? 6'($urandom) : 6'b0;
      if (evr != 0) pulse(evr);
      if ($urandom % 2 == 0) clearSticky(6'($urandom));
      settle();
      checkIrq("R7 R9 R10 random");
      if (it % 4 == 0) checkStatus("R3 R4 R5 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule